// File: doc/BRIEF.md
# Multi-Channel Up/Down PWM Timer

This block is a free-running 16-bit count engine shared by twelve pulse-width outputs. The count can climb or fall. A period register sets the cycle length. Counting up, the count returns to zero on the clock after it reaches the period. Counting down, it reloads the period on the clock after it reaches zero.

Each output compares the shared count against its own threshold. The comparison is strict (count below threshold) while climbing and inclusive (count at or below threshold) while falling. A 2-bit mode per output selects one of four behaviours:

- low-then-high PWM polarity,
- the inverted polarity,
- a fixed 0,
- a fixed 1.

An enable bit per output chooses between the PWM result and a plain software-written level bit.

All configuration arrives over a single-cycle write port with no handshake. The port is a control path: every write is accepted on the clock edge where the strobe is high. The pins are combinational functions of the registered count and the registered configuration, so they settle within the cycle that follows the edge.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0 and every register is 0: run, direction, period, thresholds, modes, enables and level bits. All pins are therefore 0.
- R2: With run=1 and direction up (control bit1=0), the count rises by 1 per clock. When the count is at or above the period, the next clock sets it to 0.
- R3: With run=1 and direction down (control bit1=1), the count falls by 1 per clock. When the count is 0, or above the period, the next clock loads the period.
- R4: With run=0 (control bit0=0), the count holds its value.
- R5: With mode 00 while counting up, a pin is 0 when count < threshold and 1 otherwise.
- R6: With mode 00 while counting down, a pin is 0 when count <= threshold and 1 otherwise.
- R7: Mode 01 gives the complement of mode 00 under the same comparisons.
- R8: Mode 10 holds the pin at 0 and mode 11 holds it at 1, whatever the count.
- R9: With its enable bit at 0, a pin equals its level bit, whatever the mode and count.
- R10: Write map. Address 0 is control: bit0 run, bit1 down. Address 1 is the period. Address 2 holds the enables, bit i for output i. Address 3 holds the level bits, bit i for output i. Address 4 holds the modes, bits [2i+1:2i] for output i. Address 16+i is the threshold of output i. A write takes effect from the clock edge on which it is sampled.
- R11: Outputs are independent. Each one uses only its own threshold, mode, enable and level bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 5 | Register address |
| wr_data | input | 24 | Write data (2 x channel count bits) |
| count_o | output | 16 | Current count value |
| pwm_o | output | 12 | Output pins, bit i is output i |

## Verification
A write or a count step lands on the rising edge that samples it. The pins follow combinationally from the registers, so every result is due in the same cycle as the edge that caused it and is never delayed further. The bench drives each stimulus at a falling edge, lets exactly one rising edge pass, and then compares at the next falling edge. At that falling edge both the count and all twelve pins must already match a model that advances once per rising edge. The model applies each write only after it has taken the count step that used the old settings.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int ADR_CTRL   = 0;
  localparam int ADR_PERIOD = 1;
  localparam int ADR_ENABLE = 2;
  localparam int ADR_LEVEL  = 3;
  localparam int ADR_MODE   = 4;
  localparam int ADR_THRESH = 16;

  typedef enum logic [1:0] {
    MODE_LOW_FIRST  = 2'b00,
    MODE_HIGH_FIRST = 2'b01,
    MODE_FORCE0     = 2'b10,
    MODE_FORCE1     = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 12,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [2*NCH-1:0]  wr_data,
  output logic              run,
  output logic              down,
  output logic [CW-1:0]     period,
  output logic [NCH-1:0]    enable,
  output logic [NCH-1:0]    level,
  output logic [2*NCH-1:0]  mode,
  output logic [NCH*CW-1:0] thresh
);
  localparam int DW = 2 * NCH;

  // Scalar configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      down   <= 1'b0;
      period <= '0;
      enable <= '0;
      level  <= '0;
      mode   <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CTRL)) begin
        run  <= wr_data[0];
        down <= wr_data[1];
      end
      if (wr_addr == AW'(ADR_PERIOD)) period <= wr_data[CW-1:0];
      if (wr_addr == AW'(ADR_ENABLE)) enable <= wr_data[NCH-1:0];
      if (wr_addr == AW'(ADR_LEVEL))  level  <= wr_data[NCH-1:0];
      if (wr_addr == AW'(ADR_MODE))   mode   <= wr_data[DW-1:0];
    end
  end

  // One threshold register per channel
  for (genvar i = 0; i < NCH; i++) begin : g_thresh
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thresh[i*CW +: CW] <= '0;
      else if (wr_en && wr_addr == AW'(ADR_THRESH + i))
        thresh[i*CW +: CW] <= wr_data[CW-1:0];
    end
  end

  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(ADR_CTRL) |=> run == $past(wr_data[0]) && down == $past(wr_data[1]));

  p_period_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == AW'(ADR_PERIOD) |=> period == $past(wr_data[CW-1:0]));

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(ADR_MODE)) |=> $stable(mode));
endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          down,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (run) begin
      if (!down) begin
        if (cnt >= period) cnt_nxt = '0;
        else               cnt_nxt = cnt + CW'(1);
      end else begin
        if (cnt == '0 || cnt > period) cnt_nxt = period;
        else                           cnt_nxt = cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !down && cnt < period |=> cnt == $past(cnt) + CW'(1));

  p_up_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run && !down && cnt >= period |=> cnt == '0);

  p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && down && cnt != '0 && cnt <= period |=> cnt == $past(cnt) - CW'(1));

  p_down_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && down && (cnt == '0 || cnt > period) |=> cnt == $past(period));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          down,
  input  logic [CW-1:0] thresh,
  input  logic [1:0]    mode,
  input  logic          enable,
  input  logic          level,
  output logic          pin
);
  logic below;
  logic pwm;

  // Strict compare on the way up, inclusive on the way down
  assign below = down ? (cnt <= thresh) : (cnt < thresh);

  always_comb begin
    unique case (chan_mode_e'(mode))
      MODE_LOW_FIRST:  pwm = ~below;
      MODE_HIGH_FIRST: pwm = below;
      MODE_FORCE0:     pwm = 1'b0;
      MODE_FORCE1:     pwm = 1'b1;
      default:         pwm = 1'b0;
    endcase
  end

  assign pin = enable ? pwm : level;

  p_force_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enable && mode == 2'b10 |-> !pin);

  p_force_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enable && mode == 2'b11 |-> pin);

  p_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> pin == level);

  p_zero_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enable && mode == 2'b00 && !down && cnt == '0 && thresh != '0 |-> !pin);
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int NCH = 12,
  parameter int CW  = 16,
  parameter int AW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [2*NCH-1:0] wr_data,
  output logic [CW-1:0]    count_o,
  output logic [NCH-1:0]   pwm_o
);
  logic              run;
  logic              down;
  logic [CW-1:0]     period;
  logic [NCH-1:0]    enable;
  logic [NCH-1:0]    level;
  logic [2*NCH-1:0]  mode;
  logic [NCH*CW-1:0] thresh;
  logic [CW-1:0]     cnt;

  pwm_timer_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run     (run),
    .down    (down),
    .period  (period),
    .enable  (enable),
    .level   (level),
    .mode    (mode),
    .thresh  (thresh)
  );

  pwm_timer_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .down   (down),
    .period (period),
    .cnt    (cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    pwm_timer_chan #(.CW(CW)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .down   (down),
      .thresh (thresh[i*CW +: CW]),
      .mode   (mode[2*i +: 2]),
      .enable (enable[i]),
      .level  (level[i]),
      .pin    (pwm_o[i])
    );
  end

  assign count_o = cnt;

  p_reset_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pwm_o == '0);
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
  localparam int NCH = 12;
  localparam int CW  = 16;
  localparam int AW  = 5;
  localparam int DW  = 2 * NCH;
  localparam int NV  = 10;

  // vector: [20] down, [19:18] mode, [17] enable, [16] level, [15:0] threshold
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 2'b00, 1'b1, 1'b0, 16'd4},   // R5
    {1'b0, 2'b01, 1'b1, 1'b0, 16'd4},   // R7 up
    {1'b1, 2'b00, 1'b1, 1'b0, 16'd4},   // R6
    {1'b1, 2'b01, 1'b1, 1'b0, 16'd4},   // R7 down
    {1'b0, 2'b10, 1'b1, 1'b1, 16'd3},   // R8 force 0
    {1'b1, 2'b11, 1'b1, 1'b0, 16'd3},   // R8 force 1
    {1'b0, 2'b00, 1'b0, 1'b1, 16'd4},   // R9 level 1
    {1'b0, 2'b00, 1'b1, 1'b0, 16'd0},   // R5 threshold 0
    {1'b0, 2'b00, 1'b1, 1'b0, 16'd12},  // R5 threshold above period
    {1'b1, 2'b01, 1'b0, 1'b0, 16'd2}    // R9 level 0
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [DW-1:0]   wr_data;
  logic [CW-1:0]   count_o;
  logic [NCH-1:0]  pwm_o;

  pwm_timer #(.NCH(NCH), .CW(CW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count_o(count_o), .pwm_o(pwm_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model state
  logic           s_run, s_down;
  logic [CW-1:0]  s_period, m_cnt;
  logic [NCH-1:0] s_en, s_lvl;
  logic [DW-1:0]  s_mode;
  logic [CW-1:0]  s_thr [NCH];

  function automatic logic exp_pin(int ch);
    logic b;
    if (!s_en[ch]) return s_lvl[ch];
    b = s_down ? (m_cnt <= s_thr[ch]) : (m_cnt < s_thr[ch]);
    case (s_mode[2*ch +: 2])
      2'b00:   return ~b;
      2'b01:   return b;
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string pin_tag(int ch);
    if (!s_en[ch]) return "R9";
    case (s_mode[2*ch +: 2])
      2'b00:   return s_down ? "R6" : "R5";
      2'b01:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string ctag;
    ctag = !s_run ? "R4" : (s_down ? "R3" : "R2");
    check_val(ctag, int'(count_o), int'(m_cnt));
    for (int ch = 0; ch < NCH; ch++)
      check_val({pin_tag(ch), " R11"}, int'(pwm_o[ch]), int'(exp_pin(ch)));
  endtask

  // One clock: drive at falling edge, one rising edge, model step, then check
  task automatic cyc(input bit we, input int a, input logic [DW-1:0] d);
    wr_en = we; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    if (s_run) begin
      if (!s_down) m_cnt = (m_cnt >= s_period) ? '0 : m_cnt + CW'(1);
      else         m_cnt = (m_cnt == '0 || m_cnt > s_period) ? s_period : m_cnt - CW'(1);
    end
    if (we) begin  // R10 write map
      if (a == 0) begin s_run = d[0]; s_down = d[1]; end
      if (a == 1) s_period = d[CW-1:0];
      if (a == 2) s_en = d[NCH-1:0];
      if (a == 3) s_lvl = d[NCH-1:0];
      if (a == 4) s_mode = d;
      if (a >= 16 && a < 16 + NCH) s_thr[a-16] = d[CW-1:0];
    end
    wr_en = 1'b0;
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    s_run = 0; s_down = 0; s_period = '0; m_cnt = '0;
    s_en = '0; s_lvl = '0; s_mode = '0;
    for (int i = 0; i < NCH; i++) s_thr[i] = '0;
    check_val("R1 count", int'(count_o), 0);
    check_val("R1 pins", int'(pwm_o), 0);
  endtask

  initial begin
    do_reset();
    // R1: mode resets to 00 and threshold to 0, so enabling alone gives 1
    cyc(1, 2, DW'(1));
    check_val("R1 mode reset", int'(pwm_o[0]), 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int ch;
      ch = v % NCH;
      do_reset();
      cyc(1, 1, DW'(9));
      cyc(1, 16 + ch, DW'(VEC[v][15:0]));
      cyc(1, 4, DW'(VEC[v][19:18]) << (2*ch));
      cyc(1, 2, DW'(VEC[v][17]) << ch);
      cyc(1, 3, DW'(VEC[v][16]) << ch);
      cyc(1, 0, {{(DW-2){1'b0}}, VEC[v][20], 1'b1});
      for (int k = 0; k < 24; k++) cyc(0, 0, '0);
    end

    // R4: stop holds the count
    do_reset();
    cyc(1, 1, DW'(9));
    cyc(1, 0, DW'(1));
    for (int k = 0; k < 5; k++) cyc(0, 0, '0);
    cyc(1, 0, DW'(0));
    for (int k = 0; k < 4; k++) cyc(0, 0, '0);
    check_val("R4 hold", int'(count_o), 6);

    // R2: period lowered below the count wraps to 0
    do_reset();
    cyc(1, 1, DW'(9));
    cyc(1, 0, DW'(1));
    for (int k = 0; k < 7; k++) cyc(0, 0, '0);
    cyc(1, 1, DW'(3));
    check_val("R2 period shrink", int'(count_o), 8);
    cyc(0, 0, '0);
    check_val("R2 wrap", int'(count_o), 0);

    // R3: count above period in down mode reloads period
    do_reset();
    cyc(1, 1, DW'(9));
    cyc(1, 0, DW'(1));
    for (int k = 0; k < 7; k++) cyc(0, 0, '0);
    cyc(1, 0, DW'(3));
    cyc(1, 1, DW'(3));
    cyc(0, 0, '0);
    check_val("R3 clamp", int'(count_o), 3);
    for (int k = 0; k < 10; k++) cyc(0, 0, '0);

    // R11: all channels at once, mixed settings; R10 live threshold change
    do_reset();
    cyc(1, 1, DW'(11));
    for (int i = 0; i < NCH; i++) cyc(1, 16 + i, DW'(i));
    cyc(1, 4, DW'(24'h1B_E4E4));
    cyc(1, 2, DW'(12'hEFF));
    cyc(1, 3, DW'(12'h100));
    cyc(1, 0, DW'(1));
    for (int k = 0; k < 26; k++) cyc(0, 0, '0);
    cyc(1, 16 + 4, DW'(8));
    for (int k = 0; k < 6; k++) cyc(0, 0, '0);
    cyc(1, 0, DW'(3));
    for (int k = 0; k < 26; k++) cyc(0, 0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule